// File: doc/BRIEF.md
# Elitist Single-Parent Evolution Sequencer

This block runs a (1+λ) evolution strategy in hardware over a small bank of chromosome registers. On a start pulse it loads a 32-bit LFSR from a seed and fills λ slots with random chromosomes. It then offers each slot, one at a time, to an external fitness evaluator and keeps the best one as the parent. Each later generation refills every slot with a mutant of the parent. A mutant is made by toggling a fixed number of randomly chosen genes. The offspring are scored and the best individual seen so far becomes the new parent.

A run stops in one of two ways. The parent's fitness may reach a programmable target, or a parameterised number of offspring generations may complete. Either way the block raises `done` and holds the parent chromosome, its fitness and the number of offspring generations that were evaluated. There is no crossover. At any time the block stores only the parent and λ offspring.

The evaluator sees a chromosome and a valid flag. It answers with a one-cycle fitness strobe. The block needs no other coordination.

Top module: `evo_one_plus_lambda`

## Requirements
- R1: After synchronous active-low reset, `done` and `eval_valid` are low and `gen_count` is 0.
- R2: A `start` pulse (accepted only while idle or done) loads `seed` into a 32-bit Galois LFSR with taps 0x80200003, shifting right. A zero seed is replaced by 1, so seed 0 and seed 1 give the same run. The same seed with the same fitness answers always gives the same chromosome sequence.
- R3: The first LAMBDA chromosomes offered are the initial population. Each is built from successive LFSR words, and they are presented in slot order with no two of them equal.
- R4: While `eval_valid` is high and `fit_valid` is low, `eval_valid` stays high and `eval_chrom` does not change. A cycle with both high completes one evaluation.
- R5: From the second generation on, every chromosome offered differs from the current parent in at most FLIPS genes, and that count has the same parity as FLIPS. FLIPS is CHROM_W*MUT_PCT/100 rounded half up, but at least 1.
- R6: Within a generation, a scored individual whose fitness is greater than or equal to the best so far (the parent, or zero at the start of a run) becomes the best. On ties, the later offspring wins.
- R7: An offspring scoring below the current best is discarded. The parent's fitness never decreases within a run.
- R8: The run ends after a selection in which the parent's fitness is at least `target_fit`; this check includes the selection after the initial population. `gen_count` then reports the number of offspring generations evaluated.
- R9: If the target is never reached, the run ends after exactly MAX_GEN offspring generations, with `gen_count` equal to MAX_GEN.
- R10: Once `done` is high it stays high, with `best_chrom` and `best_fit` stable and `eval_valid` low, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (idle or done only) |
| seed | input | 32 | LFSR seed, sampled with start |
| target_fit | input | FIT_W | Fitness that ends a run early |
| eval_valid | output | 1 | Chromosome offered for scoring |
| eval_chrom | output | CHROM_W | Chromosome under evaluation |
| fit_valid | input | 1 | Fitness answer strobe |
| fit_value | input | FIT_W | Fitness of the offered chromosome |
| done | output | 1 | Run finished |
| best_chrom | output | CHROM_W | Parent chromosome (final when done) |
| best_fit | output | FIT_W | Parent fitness (final when done) |
| gen_count | output | $clog2(MAX_GEN+1) | Offspring generations evaluated |

## Verification
The bench builds the block with 64-bit chromosomes, λ = 5, a 5 % rate (three flips per mutant) and a generation limit of 12. With these values a run that never reaches its target ends after a few hundred cycles, so the limit case is cheap to exercise. The 64-bit width makes each chromosome take two LFSR words, which exercises multi-word filling. Its scoring function counts the bits that match a fixed pattern, so fitness ties between offspring occur often and the tie rule is tested. Target values of 20, 38 and an unreachable 65 cover stopping at the initial selection, stopping partway through a run, and stopping at the limit.

// File: rtl/evo_pkg.sv
// Shared definitions for the (1+lambda) evolution sequencer.
// Assumes: one clock domain, synchronous active-low reset everywhere.
package evo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_EVAL,
        ST_SELECT,
        ST_MUTATE,
        ST_DONE
    } evo_state_t;

    // Right-shifting Galois feedback mask, x^32 + x^22 + x^2 + x + 1.
    localparam logic [31:0] LFSR_TAPS     = 32'h8020_0003;
    localparam logic [31:0] LFSR_FALLBACK = 32'h0000_0001;

endpackage

// File: rtl/evo_lfsr.sv
// 32-bit maximal-length Galois LFSR used as the random source.
// Loads a seed on request (zero seed replaced by a fixed nonzero value)
// and advances one step per cycle while step is high.
// Assumes load and step are never high together.
module evo_lfsr
    import evo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] seed,
    input  logic        step,
    output logic [31:0] q
);

    logic [31:0] q_q;

    // Seed load or one Galois shift per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= LFSR_FALLBACK;
        end else if (load) begin
            q_q <= (seed == '0) ? LFSR_FALLBACK : seed;
        end else if (step) begin
            q_q <= {1'b0, q_q[31:1]} ^ (q_q[0] ? LFSR_TAPS : 32'h0);
        end
    end

    assign q = q_q;

    // R2: the generator never falls into the all-zero lock-up state.
    a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q_q != 32'h0);

endmodule

// File: rtl/evo_flip_pick.sv
// Turns 16 random bits into a one-hot gene-flip mask.
// The gene index is the random fraction scaled by CHROM_W, which avoids a
// modulo divider. Assumes CHROM_W >= 2.
module evo_flip_pick #(
    parameter int CHROM_W = 64
) (
    input  logic [15:0]        rnd,
    output logic [CHROM_W-1:0] mask
);

    localparam int IW = $clog2(CHROM_W);

    logic [IW-1:0] idx;

    // Scale the random fraction onto the gene range, then decode it.
    always_comb begin
        idx  = IW'((32'(rnd) * CHROM_W) >> 16);
        mask = {{(CHROM_W-1){1'b0}}, 1'b1} << idx;
    end

endmodule

// File: rtl/evo_best_track.sv
// Running record of the best individual within a generation.
// clr starts a run (fitness zero, parent slot), rebase keeps the fitness
// but points back at the parent after selection, upd offers one score.
// Equal scores replace the current best (neutral drift).
module evo_best_track #(
    parameter int FIT_W     = 16,
    parameter int SW        = 3,
    parameter int PARENT_ID = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rebase,
    input  logic             upd,
    input  logic [SW-1:0]    upd_idx,
    input  logic [FIT_W-1:0] upd_fit,
    output logic [SW-1:0]    best_idx,
    output logic [FIT_W-1:0] best_fit
);

    logic [SW-1:0]    idx_q;
    logic [FIT_W-1:0] fit_q;

    // Keep the highest score seen, the later one on a tie.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx_q <= SW'(PARENT_ID);
            fit_q <= '0;
        end else if (rebase) begin
            idx_q <= SW'(PARENT_ID);
        end else if (upd && upd_fit >= fit_q) begin
            idx_q <= upd_idx;
            fit_q <= upd_fit;
        end
    end

    assign best_idx = idx_q;
    assign best_fit = fit_q;

    // R6: an equal or better score takes over as best.
    a_r6_take_equal_or_better: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && !rebase && upd_fit >= best_fit)
        |=> (best_idx == $past(upd_idx) && best_fit == $past(upd_fit)));

    // R7: a worse score leaves the best untouched.
    a_r7_keep_parent_on_worse: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && !rebase && upd_fit < best_fit)
        |=> ($stable(best_idx) && $stable(best_fit)));

    // R7: the best fitness only rises during a run.
    a_r7_fit_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_fit >= $past(best_fit));

endmodule

// File: rtl/evo_one_plus_lambda.sv
// (1+lambda) evolution sequencer.
// Fills LAMBDA slots from the LFSR, offers each to an evaluator, keeps the
// fittest as parent, then refills every slot with a FLIPS-gene mutant of
// the parent, one flip per cycle. Stops on target fitness or MAX_GEN.
// Assumes the evaluator answers each offer with a one-cycle fit_valid.
module evo_one_plus_lambda
    import evo_pkg::*;
#(
    parameter int CHROM_W = 64,
    parameter int LAMBDA  = 5,
    parameter int FIT_W   = 16,
    parameter int MAX_GEN = 5000,
    parameter int MUT_PCT = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [31:0]                  seed,
    input  logic [FIT_W-1:0]             target_fit,
    output logic                         eval_valid,
    output logic [CHROM_W-1:0]           eval_chrom,
    input  logic                         fit_valid,
    input  logic [FIT_W-1:0]             fit_value,
    output logic                         done,
    output logic [CHROM_W-1:0]           best_chrom,
    output logic [FIT_W-1:0]             best_fit,
    output logic [$clog2(MAX_GEN+1)-1:0] gen_count
);

    localparam int FLIPS_RAW = (CHROM_W * MUT_PCT + 50) / 100;
    localparam int FLIPS     = (FLIPS_RAW < 1) ? 1 : FLIPS_RAW;
    localparam int CHUNKS    = (CHROM_W + 31) / 32;
    localparam int CNT_MAX   = (CHUNKS > FLIPS) ? CHUNKS : FLIPS;
    localparam int CW        = $clog2(CNT_MAX + 1);
    localparam int SW        = $clog2(LAMBDA + 1);
    localparam int GW        = $clog2(MAX_GEN + 1);
    localparam int PARENT_ID = LAMBDA;

    evo_state_t       state_q;
    logic [SW-1:0]    cur_q;
    logic [CW-1:0]    cnt_q;
    logic [GW-1:0]    gen_q;
    logic [CHROM_W-1:0] parent_q;
    logic [CHROM_W-1:0] slot_q [LAMBDA];

    logic [31:0]        rnd;
    logic [CHROM_W-1:0] flip_mask;
    logic [CHROM_W-1:0] fill_word;
    logic [SW-1:0]      trk_idx;
    logic [FIT_W-1:0]   trk_fit;
    logic               run_clr;
    logic               last_cnt_fill, last_cnt_mut, last_slot;

    assign run_clr = start && (state_q == ST_IDLE || state_q == ST_DONE);

    evo_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (run_clr),
        .seed  (seed),
        .step  (state_q == ST_FILL || state_q == ST_MUTATE),
        .q     (rnd)
    );

    evo_flip_pick #(.CHROM_W(CHROM_W)) u_flip (
        .rnd  (rnd[15:0]),
        .mask (flip_mask)
    );

    evo_best_track #(.FIT_W(FIT_W), .SW(SW), .PARENT_ID(PARENT_ID)) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (run_clr),
        .rebase   (state_q == ST_SELECT),
        .upd      (state_q == ST_EVAL && fit_valid),
        .upd_idx  (cur_q),
        .upd_fit  (fit_value),
        .best_idx (trk_idx),
        .best_fit (trk_fit)
    );

    // Shift one 32-bit random word into the slot being filled.
    generate
        if (CHROM_W > 32) begin : g_wide_fill
            assign fill_word = {slot_q[cur_q][CHROM_W-33:0], rnd};
        end else begin : g_narrow_fill
            assign fill_word = rnd[CHROM_W-1:0];
        end
    endgenerate

    // Decode the end of a per-slot step sequence and of the slot sweep.
    always_comb begin
        last_cnt_fill = (cnt_q == CW'(CHUNKS - 1));
        last_cnt_mut  = (cnt_q == CW'(FLIPS - 1));
        last_slot     = (cur_q == SW'(LAMBDA - 1));
    end

    // Sequencer: fill, evaluate, select, mutate, until a stop condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            cnt_q    <= '0;
            gen_q    <= '0;
            parent_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q <= ST_FILL;
                        cur_q   <= '0;
                        cnt_q   <= '0;
                        gen_q   <= '0;
                    end
                end
                ST_FILL: begin
                    slot_q[cur_q] <= fill_word;
                    if (last_cnt_fill) begin
                        cnt_q <= '0;
                        if (last_slot) begin
                            cur_q   <= '0;
                            state_q <= ST_EVAL;
                        end else begin
                            cur_q <= cur_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_EVAL: begin
                    if (fit_valid) begin
                        if (last_slot) state_q <= ST_SELECT;
                        else           cur_q   <= cur_q + 1'b1;
                    end
                end
                ST_SELECT: begin
                    if (trk_idx != SW'(PARENT_ID)) parent_q <= slot_q[trk_idx];
                    if (trk_fit >= target_fit || gen_q == GW'(MAX_GEN)) begin
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_MUTATE;
                        cur_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_MUTATE: begin
                    slot_q[cur_q] <= ((cnt_q == '0) ? parent_q : slot_q[cur_q]) ^ flip_mask;
                    if (last_cnt_mut) begin
                        cnt_q <= '0;
                        if (last_slot) begin
                            cur_q   <= '0;
                            gen_q   <= gen_q + 1'b1;
                            state_q <= ST_EVAL;
                        end else begin
                            cur_q <= cur_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign eval_valid = (state_q == ST_EVAL);
    assign eval_chrom = slot_q[cur_q];
    assign done       = (state_q == ST_DONE);
    assign best_chrom = parent_q;
    assign best_fit   = trk_fit;
    assign gen_count  = gen_q;

    // R4: an unanswered offer is held steady.
    a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid && !fit_valid) |=> (eval_valid && $stable(eval_chrom)));

    // R8: reaching the target at selection ends the run.
    a_r8_stop_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELECT && trk_fit >= target_fit) |=> done);

    // R9: the generation count never passes its limit.
    a_r9_gen_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gen_count <= GW'(MAX_GEN));

    // R10: results stay frozen while finished and not restarted.
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(best_chrom) && $stable(best_fit)));

endmodule

// File: tb/evo_one_plus_lambda_tb_top.sv
// Scoreboard bench: the evaluator monitor scores each offer, checks it
// against a model parent and pushes one expected record per generation;
// the run driver pops the records and compares them with the results.
module evo_one_plus_lambda_tb_top;

    localparam int CW    = 64;
    localparam int LAM   = 5;
    localparam int FW    = 16;
    localparam int MG    = 12;
    localparam int MP    = 5;
    localparam int FLIPS = (((CW * MP + 50) / 100) < 1) ? 1 : (CW * MP + 50) / 100;
    localparam logic [CW-1:0] GOAL = 64'hA5C3_0F96_3C5A_E781;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [31:0] seed_in = '0;
    logic [FW-1:0] target = '0;
    logic eval_valid;
    logic [CW-1:0] eval_chrom;
    logic fit_valid = 1'b0;
    logic [FW-1:0] fit_value = '0;
    logic done;
    logic [CW-1:0] best_chrom;
    logic [FW-1:0] best_fit;
    logic [$clog2(MG+1)-1:0] gen_count;

    int n_chk = 0, n_fail = 0;
    int xfer = 0;
    logic [CW-1:0] m_parent, m_best;
    int m_parent_fit, m_best_fit;
    logic [CW-1:0] init_seen [LAM];

    typedef struct { logic [CW-1:0] c; int f; int g; } gen_rec_t;
    gen_rec_t exp_q [$];

    always #5 clk = ~clk;

    evo_one_plus_lambda #(.CHROM_W(CW), .LAMBDA(LAM), .FIT_W(FW),
                          .MAX_GEN(MG), .MUT_PCT(MP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed_in),
        .target_fit(target), .eval_valid(eval_valid), .eval_chrom(eval_chrom),
        .fit_valid(fit_valid), .fit_value(fit_value), .done(done),
        .best_chrom(best_chrom), .best_fit(best_fit), .gen_count(gen_count)
    );

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int fitness(input logic [CW-1:0] c);
        return $countones(~(c ^ GOAL));
    endfunction

    // Model step for one scored chromosome.
    task automatic score(input logic [CW-1:0] c);
        int grp, pos, hd, f;
        grp = xfer / LAM;
        pos = xfer % LAM;
        if (grp == 0) begin
            if (pos == 0) m_best_fit = -1;
            for (int j = 0; j < pos; j++)
                chk(c != init_seen[j], $sformatf("R3 initial slot %0d equals slot %0d: act %h exp distinct", pos, j, c));
            init_seen[pos] = c;
        end else begin
            hd = $countones(c ^ m_parent);
            chk(hd <= FLIPS && (hd % 2) == (FLIPS % 2),
                $sformatf("R5 mutant distance act %0d exp <=%0d same parity", hd, FLIPS));
        end
        f = fitness(c);
        if (f >= m_best_fit) begin
            m_best = c;
            m_best_fit = f;
        end
        if (pos == LAM - 1) begin
            m_parent = m_best;
            m_parent_fit = m_best_fit;
            exp_q.push_back('{m_parent, m_parent_fit, grp});
        end
        xfer++;
    endtask

    // Evaluator monitor: answers offers after a varying delay.
    initial begin
        bit pending;
        logic [CW-1:0] held;
        int wt;
        pending = 0;
        forever begin
            @(negedge clk);
            if (fit_valid) begin
                fit_valid = 1'b0;
            end else if (pending) begin
                chk(eval_valid && eval_chrom == held,
                    $sformatf("R4 offer not held: act v=%0b %h exp v=1 %h", eval_valid, eval_chrom, held));
                if (wt == 0) begin
                    score(held);
                    fit_value = FW'(fitness(held));
                    fit_valid = 1'b1;
                    pending = 0;
                end else begin
                    wt--;
                end
            end
            if (!pending && !fit_valid && eval_valid) begin
                pending = 1;
                held = eval_chrom;
                wt = (xfer * 7) % 4;
            end
        end
    end

    task automatic run(input logic [31:0] s, input logic [FW-1:0] tgt);
        int cyc, exp_gen;
        gen_rec_t last;
        exp_q.delete();
        xfer = 0;
        target = tgt;
        seed_in = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, $sformatf("R8 R9 run did not end: act done=%0b exp 1", done));
        exp_gen = MG;
        foreach (exp_q[i]) begin
            if (exp_q[i].f >= int'(tgt)) begin
                exp_gen = exp_q[i].g;
                break;
            end
        end
        chk(int'(gen_count) == exp_gen,
            $sformatf("R8 R9 gen_count act %0d exp %0d", gen_count, exp_gen));
        chk(exp_q.size() == int'(gen_count) + 1 && xfer == (int'(gen_count) + 1) * LAM,
            $sformatf("R9 evaluations act %0d exp %0d", xfer, (int'(gen_count) + 1) * LAM));
        if (exp_q.size() > 0) begin
            while (exp_q.size() > 1) void'(exp_q.pop_front());
            last = exp_q.pop_front();
            chk(best_chrom == last.c && int'(best_fit) == last.f,
                $sformatf("R6 R7 result act %h/%0d exp %h/%0d", best_chrom, best_fit, last.c, last.f));
        end
        repeat (3) @(negedge clk);
        chk(done && !eval_valid && best_chrom == m_parent,
            $sformatf("R10 after done act done=%0b v=%0b exp done=1 v=0", done, eval_valid));
    endtask

    initial begin
        logic [CW-1:0] init_a [LAM];
        logic [CW-1:0] res_a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done, $sformatf("R1 done act %0b exp 0", done));
        chk(!eval_valid, $sformatf("R1 eval_valid act %0b exp 0", eval_valid));
        chk(gen_count == '0, $sformatf("R1 gen_count act %0d exp 0", gen_count));

        // Unreachable target: runs to the generation limit (R9).
        run(32'h1234_5678, 16'd65);
        init_a = init_seen;
        res_a = best_chrom;
        chk(gen_count == MG, $sformatf("R9 limit act %0d exp %0d", gen_count, MG));

        // Same seed repeats the run (R2).
        run(32'h1234_5678, 16'd65);
        for (int i = 0; i < LAM; i++)
            chk(init_seen[i] == init_a[i], $sformatf("R2 repeat slot %0d act %h exp %h", i, init_seen[i], init_a[i]));
        chk(best_chrom == res_a, $sformatf("R2 repeat result act %h exp %h", best_chrom, res_a));

        // Zero seed behaves as seed 1 (R2).
        run(32'h0, 16'd65);
        init_a = init_seen;
        run(32'h1, 16'd65);
        for (int i = 0; i < LAM; i++)
            chk(init_seen[i] == init_a[i], $sformatf("R2 zero seed slot %0d act %h exp %h", i, init_a[i], init_seen[i]));

        // Low target: stops at the initial selection (R8).
        run(32'hCAFE_0001, 16'd20);
        chk(gen_count == '0, $sformatf("R8 early stop act %0d exp 0", gen_count));

        // Mid target: stops partway or at the limit per the model (R8).
        run(32'h0BAD_F00D, 16'd38);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: act running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule